// File: doc/BRIEF.md
# Keep-Alive Watchdog and Reload Monitor

This block sits on the console side of a processor and supervises a 36-bit status word that lives in memory shared with that processor. Once per tick (one second in the target system) it reads the word and takes one of three actions. If the processor has asked for a reload, the block cleans up the word, records why it acted, pulses an I/O reset and then either starts the reload or, when the boot target is not usable, halts the console. Otherwise, if keep-alive checking is enabled, it checks whether the processor has changed an 8-bit heartbeat field since the previous check. If the field stays the same for a run of checks, the block declares a keep-alive failure and asks the processor to execute the instruction at a fixed exec address.

The block does not count heartbeats. It only compares the current field against the value it sampled last time. Every change to the shared word goes through a write port that carries a bit mask, so the bits the block does not own keep their values. The forced-execute request is held until the processor acknowledges it, and there is never more than one such request open at a time.

Top module: `keepalive_supervisor`

## Requirements
- R1: While `rst` is high, the write port presents `stat_wr_en_o`=1, mask all ones and data octal 0003740000000. The stored heartbeat sample and the unchanged-checks counter are cleared, and `fx_req_o`, `io_reset_o`, `reload_start_o` and `halt_o` are 0.
- R2: A tick that sees bit 31 (reload request) set always takes the reload path, whatever the enable bit and the counter state are. That tick changes neither the stored sample nor the counter, and it raises no forced execute.
- R3: On the reload path the cycle after the tick writes with mask octal 0030000177777 (bits 31, 30 and 15:0), so that bits 31 and 30 and the heartbeat field at bits 15:8 become 0 and the reason field at bits 7:0 becomes 2. All other bits are left as they were.
- R4: On the reload path with `boot_valid_i`=1, `io_reset_o` and `reload_start_o` are each high for exactly the one cycle after the tick.
- R5: On the reload path with `boot_valid_i`=0, `io_reset_o` and `halt_o` pulse for one cycle, `reload_start_o` stays 0, and the R3 write still takes place.
- R6: With bit 31 clear and bit 30 (enable) set, a tick that finds the heartbeat field (bits 15:8) different from the stored sample stores the new value, restarts the counter and writes nothing.
- R7: When the heartbeat field is found equal to the stored sample on 15 consecutive enabled ticks, the 15th tick declares a failure. It writes the reason field (mask bits 7:0) to 1, leaves every other bit alone (so the enable bit stays set), and restarts the count.
- R8: A failure sets `fx_req_o`, with `fx_addr_o` = octal 71. The request stays high until a cycle in which `fx_ack_i` is high, and it drops in the cycle after that one.
- R9: Only one forced-execute request is outstanding at any time. A failure while a request is pending keeps `fx_req_o` high. A failure in the same cycle as `fx_ack_i` leaves it high.
- R10: A tick that finds both bit 31 and bit 30 clear causes no write and no pulses, and it changes neither the stored sample nor the counter.
- R11: Cycles without a tick cause no write and no pulses, whatever the status word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle check strobe (one per second) |
| stat_rd_i | input | 36 | Current value of the shared status word |
| boot_valid_i | input | 1 | High when the boot target is present, enabled, attached and in range |
| fx_ack_i | input | 1 | Processor accepts the forced-execute request |
| stat_wr_en_o | output | 1 | Write strobe for the status word |
| stat_wr_data_o | output | 36 | Write data; only bits with a mask bit set are written |
| stat_wr_mask_o | output | 36 | Per-bit write mask |
| fx_req_o | output | 1 | Forced-execute request, held until acknowledged |
| fx_addr_o | output | 18 | Exec address to execute (octal 71) |
| io_reset_o | output | 1 | One-cycle I/O reset pulse on a reload |
| reload_start_o | output | 1 | One-cycle pulse that starts the boot |
| halt_o | output | 1 | One-cycle console halt pulse when the boot target is invalid |

## Verification
The bench builds the block with its default parameters: a failure limit of 15, the flags at bits 31 and 30, and the heartbeat field at bits 15:8. Each check is one short strobe, so the full 15-check limit fits in a few hundred cycles. That makes the exact boundary reachable: 14 unchanged checks, then a change that restarts the run, then a 15th unchanged check that fails. A second failure while the first request is still open, and an acknowledge in the same cycle as a new failure, are also within reach. The bench models the shared word itself, applies the masked writes, and checks that a reload request takes priority over a counter that is one check short of failing.

// File: rtl/ka_pkg.sv
package ka_pkg;

    localparam int unsigned WORD_W = 36;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_RELOAD,
        ACT_WATCH
    } act_e;

    typedef struct packed {
        logic              en;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] mask;
    } wr_op_t;

    // Contiguous run of ones starting at bit lsb
    function automatic logic [WORD_W-1:0] field_mask(input int lsb, input int width);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i >= lsb && i < lsb + width) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] bit_mask(input int pos);
        return field_mask(pos, 1);
    endfunction

endpackage

// File: rtl/ka_decode.sv
module ka_decode
    import ka_pkg::*;
#(
    parameter int RLD_BIT = 31,
    parameter int ENA_BIT = 30
) (
    input  logic              tick_i,
    input  logic [WORD_W-1:0] word_i,
    output act_e              act_o
);
    // Reload request outranks the heartbeat check
    always_comb begin
        act_o = ACT_IDLE;
        if (tick_i) begin
            if (word_i[RLD_BIT])      act_o = ACT_RELOAD;
            else if (word_i[ENA_BIT]) act_o = ACT_WATCH;
        end
    end
endmodule

// File: rtl/ka_stale_counter.sv
module ka_stale_counter #(
    parameter int KA_W       = 8,
    parameter int FAIL_LIMIT = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            watch_i,
    input  logic [KA_W-1:0] kav_i,
    output logic            fail_o
);
    localparam int CNT_W = $clog2(FAIL_LIMIT + 1);

    logic [KA_W-1:0]  last_q;
    logic [CNT_W-1:0] cnt_q;
    logic             same;
    logic             at_lim;

    always_comb begin
        same   = (kav_i == last_q);
        at_lim = same && (cnt_q == CNT_W'(FAIL_LIMIT - 1));
        fail_o = watch_i && at_lim;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            cnt_q  <= '0;
        end else if (watch_i) begin
            if (!same) begin
                last_q <= kav_i;
                cnt_q  <= '0;
            end else if (at_lim) begin
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assert_cnt_below_limit_R7: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) < FAIL_LIMIT)
        else $error("stale counter reached the limit");

    assert_fail_restarts_R7: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> (cnt_q == '0))
        else $error("counter not restarted after failure");

    assert_change_restarts_R6: assert property (@(posedge clk) disable iff (rst)
        (watch_i && !same) |=> (cnt_q == '0 && last_q == $past(kav_i)))
        else $error("heartbeat change not captured");
endmodule

// File: rtl/ka_fx_holder.sv
module ka_fx_holder (
    input  logic clk,
    input  logic rst,
    input  logic raise_i,
    input  logic ack_i,
    output logic req_o
);
    // A new failure wins over an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (rst)          req_o <= 1'b0;
        else if (raise_i) req_o <= 1'b1;
        else if (ack_i)   req_o <= 1'b0;
    end

    assert_fx_held_R8: assert property (@(posedge clk) disable iff (rst)
        (req_o && !ack_i) |=> req_o)
        else $error("request dropped without acknowledge");

    assert_ack_drops_R9: assert property (@(posedge clk) disable iff (rst)
        (req_o && ack_i && !raise_i) |=> !req_o)
        else $error("request survived acknowledge");

    assert_raise_sets_R9: assert property (@(posedge clk) disable iff (rst)
        raise_i |=> req_o)
        else $error("failure did not leave a request open");
endmodule

// File: rtl/keepalive_supervisor.sv
module keepalive_supervisor
    import ka_pkg::*;
#(
    parameter int                RLD_BIT    = 31,
    parameter int                ENA_BIT    = 30,
    parameter int                KA_LSB     = 8,
    parameter int                KA_W       = 8,
    parameter int                RSN_W      = 8,
    parameter int                FAIL_LIMIT = 15,
    parameter int                FX_ADDR_W  = 18,
    parameter logic [FX_ADDR_W-1:0] FX_ADDR = 18'o71,
    parameter logic [WORD_W-1:0] INIT_WORD  = 36'o0003740000000,
    parameter int                RSN_RELOAD = 2,
    parameter int                RSN_KAF    = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic [WORD_W-1:0]    stat_rd_i,
    input  logic                 boot_valid_i,
    input  logic                 fx_ack_i,
    output logic                 stat_wr_en_o,
    output logic [WORD_W-1:0]    stat_wr_data_o,
    output logic [WORD_W-1:0]    stat_wr_mask_o,
    output logic                 fx_req_o,
    output logic [FX_ADDR_W-1:0] fx_addr_o,
    output logic                 io_reset_o,
    output logic                 reload_start_o,
    output logic                 halt_o
);
    localparam logic [WORD_W-1:0] RSN_MASK = field_mask(0, RSN_W);
    localparam logic [WORD_W-1:0] RLD_CLR_MASK =
        bit_mask(RLD_BIT) | bit_mask(ENA_BIT) | field_mask(KA_LSB, KA_W) | RSN_MASK;

    act_e   act;
    logic   fail;
    logic   unused_rd;
    wr_op_t wr_q;

    assign unused_rd = ^stat_rd_i;

    ka_decode #(.RLD_BIT(RLD_BIT), .ENA_BIT(ENA_BIT)) u_decode (
        .tick_i (tick_i),
        .word_i (stat_rd_i),
        .act_o  (act)
    );

    ka_stale_counter #(.KA_W(KA_W), .FAIL_LIMIT(FAIL_LIMIT)) u_stale (
        .clk     (clk),
        .rst     (rst),
        .watch_i (act == ACT_WATCH),
        .kav_i   (stat_rd_i[KA_LSB +: KA_W]),
        .fail_o  (fail)
    );

    ka_fx_holder u_fx (
        .clk     (clk),
        .rst     (rst),
        .raise_i (fail),
        .ack_i   (fx_ack_i),
        .req_o   (fx_req_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q.en        <= 1'b1;
            wr_q.data      <= INIT_WORD;
            wr_q.mask      <= '1;
            io_reset_o     <= 1'b0;
            reload_start_o <= 1'b0;
            halt_o         <= 1'b0;
        end else begin
            wr_q.en        <= 1'b0;
            wr_q.data      <= '0;
            wr_q.mask      <= '0;
            io_reset_o     <= 1'b0;
            reload_start_o <= 1'b0;
            halt_o         <= 1'b0;
            case (act)
                ACT_RELOAD: begin
                    wr_q.en        <= 1'b1;
                    wr_q.mask      <= RLD_CLR_MASK;
                    wr_q.data      <= WORD_W'(RSN_RELOAD) & RSN_MASK;
                    io_reset_o     <= 1'b1;
                    reload_start_o <= boot_valid_i;
                    halt_o         <= !boot_valid_i;
                end
                ACT_WATCH: begin
                    if (fail) begin
                        wr_q.en   <= 1'b1;
                        wr_q.mask <= RSN_MASK;
                        wr_q.data <= WORD_W'(RSN_KAF) & RSN_MASK;
                    end
                end
                default: ;
            endcase
        end
    end

    assign stat_wr_en_o   = wr_q.en;
    assign stat_wr_data_o = wr_q.data;
    assign stat_wr_mask_o = wr_q.mask;
    assign fx_addr_o      = FX_ADDR;

    assert_io_after_tick_R4: assert property (@(posedge clk) disable iff (rst)
        io_reset_o |-> $past(tick_i))
        else $error("I/O reset without a tick");

    assert_reload_or_halt_R4: assert property (@(posedge clk) disable iff (rst)
        io_reset_o |-> (reload_start_o || halt_o))
        else $error("I/O reset without reload or halt");

    assert_halt_excl_R5: assert property (@(posedge clk) disable iff (rst)
        reload_start_o |-> !halt_o)
        else $error("reload and halt together");

    assert_quiet_no_tick_R11: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> (!stat_wr_en_o && !io_reset_o))
        else $error("activity without a tick");
endmodule

// File: tb/keepalive_supervisor_tb.sv
module keepalive_supervisor_tb;
    localparam logic [35:0] INIT    = 36'o0003740000000;
    localparam logic [35:0] CLRMASK = 36'o0030000177777;

    typedef struct {
        logic [35:0] word;
        logic        fx;
        logic        io;
        logic        rl;
        logic        hl;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        boot_valid = 1'b1;
    logic        fx_ack = 1'b0;
    logic [35:0] mem = '0;
    logic        wr_en;
    logic [35:0] wr_data, wr_mask;
    logic        fx_req, io_reset, reload_start, halt;
    logic [17:0] fx_addr;
    logic        tick_q = 1'b0;

    int   n_checks = 0;
    int   n_fail = 0;
    exp_t sb[$];
    logic [7:0] m_last = '0;
    int   m_cnt = 0;
    logic m_fx = 1'b0;

    always #5 clk = ~clk;

    keepalive_supervisor u_dut (
        .clk            (clk),
        .rst            (rst),
        .tick_i         (tick),
        .stat_rd_i      (mem),
        .boot_valid_i   (boot_valid),
        .fx_ack_i       (fx_ack),
        .stat_wr_en_o   (wr_en),
        .stat_wr_data_o (wr_data),
        .stat_wr_mask_o (wr_mask),
        .fx_req_o       (fx_req),
        .fx_addr_o      (fx_addr),
        .io_reset_o     (io_reset),
        .reload_start_o (reload_start),
        .halt_o         (halt)
    );

    // Shared memory word: apply the masked write port
    always @(posedge clk) begin
        tick_q = tick;
        if (wr_en) mem = (mem & ~wr_mask) | (wr_data & wr_mask);
    end

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %o expected %o", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected result for each tick
    always @(negedge clk) begin
        if (tick_q) begin
            if (sb.size() == 0) begin
                chk("scoreboard underflow", 36'd1, 36'd0);
            end else begin
                exp_t e;
                logic [35:0] applied;
                e = sb.pop_front();
                applied = wr_en ? ((mem & ~wr_mask) | (wr_data & wr_mask)) : mem;
                chk({e.tag, " word"}, applied, e.word);
                chk({e.tag, " fx_req"}, 36'(fx_req), 36'(e.fx));
                if (e.fx) chk({e.tag, " fx_addr R8"}, 36'(fx_addr), 36'o71);
                chk({e.tag, " io_reset"}, 36'(io_reset), 36'(e.io));
                chk({e.tag, " reload_start"}, 36'(reload_start), 36'(e.rl));
                chk({e.tag, " halt"}, 36'(halt), 36'(e.hl));
            end
        end
    end

    // Driver: one tick, expected result from the requirements
    task automatic do_tick(input logic boot_ok, input logic ack_too, input string tag);
        exp_t e;
        logic fail;
        fail   = 1'b0;
        e.word = mem;
        e.io   = 1'b0;
        e.rl   = 1'b0;
        e.hl   = 1'b0;
        e.tag  = tag;
        if (mem[31]) begin
            e.word = (mem & ~CLRMASK) | 36'd2;
            e.io   = 1'b1;
            e.rl   = boot_ok;
            e.hl   = !boot_ok;
        end else if (mem[30]) begin
            if (mem[15:8] != m_last) begin
                m_last = mem[15:8];
                m_cnt  = 0;
            end else if (m_cnt == 14) begin
                m_cnt  = 0;
                fail   = 1'b1;
                e.word = {mem[35:8], 8'd1};
            end else begin
                m_cnt++;
            end
        end
        if (fail)         m_fx = 1'b1;
        else if (ack_too) m_fx = 1'b0;
        e.fx = m_fx;
        @(negedge clk);
        sb.push_back(e);
        boot_valid = boot_ok;
        fx_ack = ack_too;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        fx_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk);
        fx_ack = 1'b1;
        @(negedge clk);
        fx_ack = 1'b0;
        m_fx = 1'b0;
        chk("R8 ack clears request", 36'(fx_req), 36'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset write enable", 36'(wr_en), 36'd1);
        chk("R1 reset data", wr_data, INIT);
        chk("R1 reset mask", wr_mask, '1);
        chk("R1 reset fx_req", 36'(fx_req), 36'd0);
        chk("R1 reset pulses", {33'd0, io_reset, reload_start, halt}, 36'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 memory initialised", mem, INIT);
        chk("R11 idle after reset", 36'(wr_en), 36'd0);

        // R10: enable clear, no reload
        do_tick(1'b1, 1'b0, "R10 disabled");
        do_tick(1'b1, 1'b0, "R10 disabled again");

        // R7: enable with constant heartbeat -> failure on 15th check
        mem[30] = 1'b1;
        mem[35:32] = 4'hA;
        for (int i = 0; i < 15; i++) do_tick(1'b1, 1'b0, "R7 unchanged run");
        chk("R7 enable kept after failure", 36'(mem[30]), 36'd1);
        chk("R8 request after failure", 36'(fx_req), 36'd1);
        do_ack();

        // R6: changing heartbeat never fails
        for (int i = 0; i < 20; i++) begin
            mem[15:8] = 8'(i + 3);
            do_tick(1'b1, 1'b0, "R6 kicking");
        end
        // 14 unchanged, change, then 15 unchanged
        for (int i = 0; i < 14; i++) do_tick(1'b1, 1'b0, "R6 near limit");
        mem[15:8] = 8'h5C;
        do_tick(1'b1, 1'b0, "R6 change restarts");
        for (int i = 0; i < 15; i++) do_tick(1'b1, 1'b0, "R7 boundary after restart");

        // R9: second failure while pending
        for (int i = 0; i < 15; i++) do_tick(1'b1, 1'b0, "R9 failure while pending");
        do_ack();
        for (int i = 0; i < 14; i++) do_tick(1'b1, 1'b0, "R9 build up");
        do_tick(1'b1, 1'b1, "R9 failure with ack same cycle");
        do_ack();

        // R2/R3/R4: reload outranks a counter one short of failing
        for (int i = 0; i < 14; i++) do_tick(1'b1, 1'b0, "R2 build up");
        mem[31] = 1'b1;
        mem[7:0] = 8'h77;
        do_tick(1'b1, 1'b0, "R2 R3 R4 reload valid");
        chk("R2 no forced execute on reload", 36'(fx_req), 36'd0);

        // R5: reload with invalid boot target
        mem[31] = 1'b1;
        mem[30] = 1'b1;
        mem[15:8] = 8'h12;
        do_tick(1'b0, 1'b0, "R5 reload invalid target");

        // R11: no tick, reload bit set
        mem[31] = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R11 no tick no write", 36'(wr_en), 36'd0);
            chk("R11 no tick no pulse", 36'(io_reset), 36'd0);
        end
        chk("R11 word untouched", 36'(mem[31]), 36'd1);

        chk("scoreboard drained", 36'(sb.size()), 36'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule